// File: doc/BRIEF.md
# I2C Transaction Generator

This block runs a whole short I2C transfer from one configuration write, with no software step per byte. Software loads two 32-bit transmit words, then writes a control word. That word carries the target address, the address width, which phases to run, the byte count of each phase and whether the read phase follows a repeated START. The generator then sends a stream of bus-level commands to the neighbouring byte engine: START, repeated START, write byte, read byte and STOP. It uses the engine's per-command responses to advance. Received bytes land in two 32-bit receive words.

Three transfer forms are supported: a write of 1 to 8 bytes, a read of 1 to 8 bytes, and a write followed by a read, each phase up to 8 bytes. Addresses may be 7 or 10 bits wide. When the transfer ends, either normally or on a NACK, a sticky completion cause is set and an error flag reports a NACK. The interrupt line is the cause gated by a mask. Software clears the control word and the cause before it starts the next transfer.

The command stream is valid/ready. A command stays on the bus with its payload unchanged until the engine takes it. Exactly one command is outstanding at a time. The engine answers every command it has taken with a single-cycle response pulse. The block ignores a response pulse when no command is outstanding. The block has no stall input on the response path.

Top module: `i2c_txn_offload`

## Requirements
- R1: After reset the control readback, both receive words, the error flag, the cause, the interrupt, `busy` and `cmd_valid` are all zero.
- R2: A control write with bit19 set while idle starts a transfer. With bit0 set there is a write phase: START (op 1), then the address byte sent as a write (op 3) with bit0 = 0, then bits[15:13]+1 data bytes taken from the low transmit word and then the high word, least significant byte first. STOP (op 5) ends a write-only transfer.
- R3: With bit1 set there is a read phase: the address byte with bit0 = 1, then bits[18:16]+1 reads (op 4). Every read but the last carries master ACK (`cmd_mack` = 1). Received byte i goes to byte lane i of {rx_hi, rx_lo}, and lanes not received read zero. A STOP follows the last read.
- R4: When both phases are requested, bit20 = 1 puts one repeated START (op 2) between them. Bit20 = 0 puts a STOP and then a START between them.
- R5: For a 7-bit address, bits[8:2] form the first address byte as {addr[6:0], dir}. When bit12 is set, the address bits[11:2] are sent as {5'b11110, addr[9:8], dir} followed by a second byte addr[7:0].
- R6: A NACK response to any written byte, whether address or data, is followed at once by STOP. The error flag is set, and no further bytes are sent or read, so the unread receive lanes stay zero.
- R7: The cause sets on the cycle the final STOP response arrives, as `busy` falls. It stays set until `cause_clr`. `irq` equals cause AND mask, where the mask is loaded from bit0 of the data bus by `mask_we`. The error flag clears at the next transfer start.
- R8: While `busy` is high, writes to the control word and to either transmit word are ignored.
- R9: The command payload (`cmd_op`, `cmd_byte`, `cmd_mack`) is stable while `cmd_valid` is high and `cmd_ready` is low. `cmd_valid` is only high during a transfer, and a response pulse with no outstanding command is ignored.
- R10: A start with neither phase bit set sends no commands. It sets the cause and the error flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wdata | input | 32 | Write data for all register strobes |
| ctl_we | input | 1 | Write control word |
| txlo_we | input | 1 | Write low transmit word |
| txhi_we | input | 1 | Write high transmit word |
| mask_we | input | 1 | Load interrupt mask from reg_wdata[0] |
| cause_clr | input | 1 | Clear completion cause |
| ctl_q | output | 32 | Control word readback |
| rx_lo | output | 32 | Receive bytes 0..3 |
| rx_hi | output | 32 | Receive bytes 4..7 |
| stat_err | output | 1 | NACK / empty-request error flag |
| cause_q | output | 1 | Completion cause |
| irq | output | 1 | Cause gated by mask |
| busy | output | 1 | Transfer in progress |
| cmd_valid | output | 1 | Bus command offered to byte engine |
| cmd_ready | input | 1 | Byte engine takes the command |
| cmd_op | output | 3 | 1 START, 2 RESTART, 3 WRITE, 4 READ, 5 STOP |
| cmd_byte | output | 8 | Byte for WRITE, zero otherwise |
| cmd_mack | output | 1 | Master ACK after a READ |
| rsp_valid | input | 1 | Single-cycle completion of the outstanding command |
| rsp_nack | input | 1 | Target did not acknowledge a written byte |
| rsp_byte | input | 8 | Byte returned by a READ |

## Verification
The assertions assume the byte engine raises `rsp_valid` only after it has taken a command, and only once for each command. They also assume software leaves `cause_clr` low on the cycle a transfer ends. The stimulus keeps to these rules through a behavioural engine model. That model takes one command at a time, holds `cmd_ready` off for zero to two cycles, and answers exactly two cycles after accepting. It injects a NACK only at a chosen written-byte index. The only stray response pulse is driven on purpose while the block is idle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int CTL_W   = 32;
  localparam int BIT_EN  = 19;
  localparam int BIT_WR  = 0;
  localparam int BIT_RD  = 1;
  localparam int CFG_W   = 21;
  localparam int LEN_W   = 3;
  localparam int TADDR_W = 10;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_STOP    = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_WA1, ST_WA2, ST_WDAT, ST_MID, ST_MID2,
    ST_RA1, ST_RA2, ST_RDAT, ST_STOP
  } step_e;

  // Field order follows the control word, most significant field first.
  typedef struct packed {
    logic               rs;
    logic               en;
    logic [LEN_W-1:0]   rxl;
    logic [LEN_W-1:0]   txl;
    logic               ten;
    logic [TADDR_W-1:0] addr;
    logic               rd;
    logic               wr;
  } cfg_t;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ctl_we,
  input  logic              txlo_we,
  input  logic              txhi_we,
  input  logic              mask_we,
  input  logic              cause_clr,
  input  logic              busy,
  input  logic              done,
  input  logic              err_set,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] tx_lo,
  output logic [WORD_W-1:0] tx_hi,
  output logic              mask_q,
  output logic              cause_q,
  output logic              err_q,
  output logic              start_go,
  output logic              start_empty
);
  logic open_w;
  logic launch;
  logic has_phase;

  assign open_w      = !busy;
  assign launch      = ctl_we && open_w && wdata[BIT_EN];
  assign has_phase   = wdata[BIT_WR] || wdata[BIT_RD];
  assign start_go    = launch && has_phase;
  assign start_empty = launch && !has_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      tx_lo <= '0;
      tx_hi <= '0;
    end else begin
      if (ctl_we && open_w)  ctl_q <= wdata;
      if (txlo_we && open_w) tx_lo <= wdata;
      if (txhi_we && open_w) tx_hi <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      cause_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata[0];
      if (done) cause_q <= 1'b1;
      else if (cause_clr) cause_q <= 1'b0;
      if (err_set) err_q <= 1'b1;
      else if (launch) err_q <= 1'b0;
    end
  end

  // R8: configuration is frozen while a transfer runs
  a_r8_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> $stable(ctl_q));
  a_r8_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (txlo_we || txhi_we)) |=> ($stable(tx_lo) && $stable(tx_hi)));
endmodule

// File: rtl/tg_rxbuf.sv
module tg_rxbuf #(
  parameter  int WORD_W    = 32,
  localparam int BUF_BYTES = 2 * WORD_W / 8,
  localparam int CNT_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] rx_lo,
  output logic [WORD_W-1:0] rx_hi
);
  logic [2*WORD_W-1:0] lanes;

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (clr)                              q <= '0;
      else if (we && (idx == CNT_W'(i)))         q <= din;
    end
    assign lanes[8*i +: 8] = q;
  end

  assign rx_lo = lanes[WORD_W-1:0];
  assign rx_hi = lanes[2*WORD_W-1:WORD_W];

  // R3: a new transfer starts with every lane empty
  a_r3_lanes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rx_lo == '0 && rx_hi == '0));
endmodule

// File: rtl/tg_seq.sv
module tg_seq
  import tg_pkg::*;
#(
  parameter  int WORD_W    = 32,
  localparam int BUF_BYTES = 2 * WORD_W / 8,
  localparam int CNT_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              start_empty,
  input  cfg_t              cfg,
  input  logic [WORD_W-1:0] tx_lo,
  input  logic [WORD_W-1:0] tx_hi,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [7:0]        rsp_byte,
  output logic              busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_mack,
  output logic              done,
  output logic              err_set,
  output logic              rx_clr,
  output logic              rx_we,
  output logic [CNT_W-1:0]  rx_idx,
  output logic [7:0]        rx_byte
);
  step_e             step, nstep;
  logic              pend;
  logic [CNT_W-1:0]  cnt, ncnt;
  logic [2*WORD_W-1:0] txw;
  logic              got, wtype, nack_ev;
  logic [7:0]        addr_w, addr_r;

  assign txw    = {tx_hi, tx_lo};
  assign addr_w = cfg.ten ? {5'b11110, cfg.addr[9:8], 1'b0} : {cfg.addr[6:0], 1'b0};
  assign addr_r = cfg.ten ? {5'b11110, cfg.addr[9:8], 1'b1} : {cfg.addr[6:0], 1'b1};

  assign busy      = (step != ST_IDLE);
  assign cmd_valid = busy && !pend;
  assign got       = pend && rsp_valid;

  always_comb begin
    wtype = 1'b0;
    case (step)
      ST_WA1, ST_WA2, ST_WDAT, ST_RA1, ST_RA2: wtype = 1'b1;
      default: wtype = 1'b0;
    endcase
  end
  assign nack_ev = got && wtype && rsp_nack;

  always_comb begin
    cmd_op   = OP_NONE;
    cmd_byte = 8'h00;
    cmd_mack = 1'b0;
    case (step)
      ST_START, ST_MID2: cmd_op = OP_START;
      ST_MID:            cmd_op = cfg.rs ? OP_RESTART : OP_STOP;
      ST_WA1:  begin cmd_op = OP_WRITE; cmd_byte = addr_w; end
      ST_RA1:  begin cmd_op = OP_WRITE; cmd_byte = addr_r; end
      ST_WA2, ST_RA2: begin cmd_op = OP_WRITE; cmd_byte = cfg.addr[7:0]; end
      ST_WDAT: begin cmd_op = OP_WRITE; cmd_byte = txw[8*int'(cnt) +: 8]; end
      ST_RDAT: begin cmd_op = OP_READ; cmd_mack = (cnt != cfg.rxl); end
      ST_STOP: cmd_op = OP_STOP;
      default: cmd_op = OP_NONE;
    endcase
  end

  always_comb begin
    nstep = step;
    ncnt  = cnt;
    case (step)
      ST_START: nstep = cfg.wr ? ST_WA1 : ST_RA1;
      ST_WA1:   nstep = cfg.ten ? ST_WA2 : ST_WDAT;
      ST_WA2:   nstep = ST_WDAT;
      ST_WDAT: begin
        if (cnt == cfg.txl) begin
          nstep = cfg.rd ? ST_MID : ST_STOP;
          ncnt  = '0;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      ST_MID:  nstep = cfg.rs ? ST_RA1 : ST_MID2;
      ST_MID2: nstep = ST_RA1;
      ST_RA1:  nstep = cfg.ten ? ST_RA2 : ST_RDAT;
      ST_RA2:  nstep = ST_RDAT;
      ST_RDAT: begin
        if (cnt == cfg.rxl) nstep = ST_STOP;
        else                ncnt  = cnt + 1'b1;
      end
      ST_STOP: nstep = ST_IDLE;
      default: nstep = ST_IDLE;
    endcase
    if (nack_ev) nstep = ST_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_IDLE;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (start_go) begin
      step <= ST_START;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      pend <= 1'b1;
    end else if (got) begin
      pend <= 1'b0;
      step <= nstep;
      cnt  <= ncnt;
    end
  end

  assign done    = (got && step == ST_STOP) || start_empty;
  assign err_set = nack_ev || start_empty;
  assign rx_clr  = start_go;
  assign rx_we   = got && (step == ST_RDAT);
  assign rx_idx  = cnt;
  assign rx_byte = rsp_byte;

  // R9: an offered command is held until taken
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)
                                   && $stable(cmd_mack)));
  // R6: a refused byte is followed by STOP
  a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> (cmd_valid && cmd_op == OP_STOP));
endmodule

// File: rtl/i2c_txn_offload.sv
module i2c_txn_offload
  import tg_pkg::*;
#(
  parameter  int WORD_W    = 32,
  localparam int BUF_BYTES = 2 * WORD_W / 8,
  localparam int CNT_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              ctl_we,
  input  logic              txlo_we,
  input  logic              txhi_we,
  input  logic              mask_we,
  input  logic              cause_clr,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] rx_lo,
  output logic [WORD_W-1:0] rx_hi,
  output logic              stat_err,
  output logic              cause_q,
  output logic              irq,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_mack,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [7:0]        rsp_byte
);
  logic [WORD_W-1:0] tx_lo, tx_hi;
  logic              mask_q, start_go, start_empty, done, err_set;
  logic              rx_clr, rx_we;
  logic [CNT_W-1:0]  rx_idx;
  logic [7:0]        rx_byte;
  cfg_t              cfg;

  assign cfg = cfg_t'(ctl_q[CFG_W-1:0]);
  assign irq = cause_q && mask_q;

  tg_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata), .ctl_we(ctl_we),
    .txlo_we(txlo_we), .txhi_we(txhi_we), .mask_we(mask_we), .cause_clr(cause_clr),
    .busy(busy), .done(done), .err_set(err_set), .ctl_q(ctl_q), .tx_lo(tx_lo),
    .tx_hi(tx_hi), .mask_q(mask_q), .cause_q(cause_q), .err_q(stat_err),
    .start_go(start_go), .start_empty(start_empty)
  );

  tg_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .start_empty(start_empty),
    .cfg(cfg), .tx_lo(tx_lo), .tx_hi(tx_hi), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_mack(cmd_mack),
    .done(done), .err_set(err_set), .rx_clr(rx_clr), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_byte(rx_byte)
  );

  tg_rxbuf #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .we(rx_we), .idx(rx_idx),
    .din(rx_byte), .rx_lo(rx_lo), .rx_hi(rx_hi)
  );

  // R7: the end of a transfer always leaves the cause set
  a_r7_cause_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cause_q);
  // R9: commands only appear inside a transfer
  a_r9_cmd_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

// File: tb/i2c_txn_offload_bench.sv
module i2c_txn_offload_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] reg_wdata;
  logic        ctl_we, txlo_we, txhi_we, mask_we, cause_clr;
  logic [31:0] ctl_q, rx_lo, rx_hi;
  logic        stat_err, cause_q, irq, busy, cmd_valid, cmd_ready, cmd_mack;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte, rsp_byte;
  logic        rsp_valid, rsp_nack;

  always #4 clk = ~clk;

  i2c_txn_offload u_i2c_txn_offload (
    .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .ctl_we(ctl_we),
    .txlo_we(txlo_we), .txhi_we(txhi_we), .mask_we(mask_we), .cause_clr(cause_clr),
    .ctl_q(ctl_q), .rx_lo(rx_lo), .rx_hi(rx_hi), .stat_err(stat_err),
    .cause_q(cause_q), .irq(irq), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_mack(cmd_mack),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [11:0] got_q[$];
  logic [11:0] exp_q[$];
  logic [63:0] exp_rx;
  logic        exp_err;
  logic        mask_model = 1'b0;
  int nack_at = -1, w_cnt = 0, r_cnt = 0, lat_sel = 0;
  int wi;
  bit nk;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // Byte engine and target model
  initial begin
    cmd_ready = 0; rsp_valid = 0; rsp_nack = 0; rsp_byte = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid === 1'b1 && rst_n === 1'b1) begin
        logic [11:0] e;
        e = {cmd_op, cmd_mack, cmd_byte};
        repeat (lat_sel % 3) @(negedge clk);
        lat_sel++;
        chk("R9", {52'd0, cmd_op, cmd_mack, cmd_byte}, {52'd0, e}, "payload held");
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        got_q.push_back(e);
        @(negedge clk);
        rsp_nack = 0; rsp_byte = 0;
        if (e[11:9] == 3'd3) begin rsp_nack = (w_cnt == nack_at); w_cnt++; end
        if (e[11:9] == 3'd4) begin rsp_byte = 8'(8'hA0 + r_cnt); r_cnt++; end
        rsp_valid = 1;
        @(negedge clk);
        rsp_valid = 0;
      end
    end
  end

  // Per-clock comparison, sampled in the high phase
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1 && !finished) begin
      chk("R7", {63'd0, irq}, {63'd0, cause_q & mask_model}, "irq gate");
      chk("R9", {63'd0, cmd_valid & ~busy}, 64'd0, "cmd outside txn");
    end
  end

  task automatic do_write(input int which, input logic [31:0] d);
    @(negedge clk);
    reg_wdata = d;
    case (which)
      0: ctl_we = 1;
      1: txlo_we = 1;
      2: txhi_we = 1;
      3: begin mask_we = 1; mask_model = d[0]; end
      default: cause_clr = 1;
    endcase
    @(negedge clk);
    ctl_we = 0; txlo_we = 0; txhi_we = 0; mask_we = 0; cause_clr = 0;
  endtask

  function automatic logic [31:0] mk_ctl(input bit wr, input bit rd, input logic [9:0] a,
      input bit ten, input int txn, input int rxn, input bit rs);
    return (32'(rs) << 20) | (32'd1 << 19) | (32'(rxn - 1) << 16) | (32'(txn - 1) << 13)
         | (32'(ten) << 12) | (32'(a) << 2) | (32'(rd) << 1) | 32'(wr);
  endfunction

  task automatic push_w(input logic [7:0] b);
    if (!nk) begin
      exp_q.push_back({3'd3, 1'b0, b});
      if (wi == nack_at) nk = 1;
      wi++;
    end
  endtask

  task automatic build_exp(input logic [31:0] c, input logic [31:0] lo, input logic [31:0] hi);
    bit wr, rd, ten, rs;
    logic [9:0] a;
    int txl, rxl;
    logic [63:0] txd;
    wr = c[0]; rd = c[1]; a = c[11:2]; ten = c[12];
    txl = int'(c[15:13]); rxl = int'(c[18:16]); rs = c[20];
    txd = {hi, lo};
    exp_q.delete(); exp_rx = '0; nk = 0; wi = 0;
    if (!wr && !rd) begin exp_err = 1; return; end
    exp_q.push_back({3'd1, 9'd0});
    if (wr) begin
      push_w(ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], 1'b0});
      if (ten) push_w(a[7:0]);
      for (int i = 0; i <= txl; i++) push_w(txd[8*i +: 8]);
      if (rd && !nk) begin
        if (rs) exp_q.push_back({3'd2, 9'd0});
        else begin exp_q.push_back({3'd5, 9'd0}); exp_q.push_back({3'd1, 9'd0}); end
      end
    end
    if (rd) begin
      push_w(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1});
      if (ten) push_w(a[7:0]);
      for (int i = 0; i <= rxl; i++) begin
        if (!nk) begin
          exp_q.push_back({3'd4, (i != rxl) ? 1'b1 : 1'b0, 8'd0});
          exp_rx[8*i +: 8] = 8'(8'hA0 + i);
        end
      end
    end
    exp_q.push_back({3'd5, 9'd0});
    exp_err = nk;
  endtask

  task automatic start_txn(input logic [31:0] c, input logic [31:0] lo, input logic [31:0] hi,
                           input int nack_i);
    nack_at = nack_i; w_cnt = 0; r_cnt = 0;
    got_q.delete();
    build_exp(c, lo, hi);
    do_write(1, lo);
    do_write(2, hi);
    do_write(0, c);
  endtask

  task automatic finish_txn(input string r);
    int k;
    k = 0;
    while (cause_q !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    chk(r, 64'(got_q.size()), 64'(exp_q.size()), "command count");
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(r, {52'd0, got_q[i]}, {52'd0, exp_q[i]}, $sformatf("command %0d", i));
    chk(r, {rx_hi, rx_lo}, exp_rx, "receive words");
    chk(r, {63'd0, stat_err}, {63'd0, exp_err}, "error flag");
    chk("R7", {63'd0, cause_q}, 64'd1, "cause held");
    chk("R7", {63'd0, busy}, 64'd0, "idle after end");
  endtask

  task automatic clear_all();
    do_write(0, 32'd0);
    do_write(4, 32'd0);
    @(negedge clk);
    chk("R7", {63'd0, cause_q}, 64'd0, "cause cleared");
  endtask

  initial begin
    logic [31:0] c;
    rst_n = 0; reg_wdata = 0; ctl_we = 0; txlo_we = 0; txhi_we = 0;
    mask_we = 0; cause_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", ctl_q, 0, "ctl readback");
    chk("R1", {rx_hi, rx_lo}, 0, "rx words");
    chk("R1", {59'd0, stat_err, cause_q, irq, busy, cmd_valid}, 0, "flags");

    // R2 write 3 bytes, 7-bit address
    start_txn(mk_ctl(1, 0, 10'h050, 0, 3, 1, 0), 32'h44332211, 32'h88776655, -1);
    finish_txn("R2"); clear_all();
    // R2 boundary: single byte write
    start_txn(mk_ctl(1, 0, 10'h07F, 0, 1, 1, 0), 32'h000000C3, 32'h0, -1);
    finish_txn("R2"); clear_all();
    // R3 read 8 bytes
    start_txn(mk_ctl(0, 1, 10'h021, 0, 1, 8, 0), 32'h0, 32'h0, -1);
    finish_txn("R3"); clear_all();
    // R3 read 5 bytes, upper lanes zero
    start_txn(mk_ctl(0, 1, 10'h012, 0, 1, 5, 0), 32'h0, 32'h0, -1);
    finish_txn("R3"); clear_all();
    // R4 R5: 10-bit address, write 2, repeated start, read 1
    start_txn(mk_ctl(1, 1, 10'h2A5, 1, 2, 1, 1), 32'hBEEF, 32'h0, -1);
    finish_txn("R5"); clear_all();
    // R4: write 1 then read 3 with STOP+START between
    start_txn(mk_ctl(1, 1, 10'h033, 0, 1, 3, 0), 32'h5A, 32'h0, -1);
    finish_txn("R4"); clear_all();
    // R6: address refused
    start_txn(mk_ctl(1, 1, 10'h044, 0, 4, 4, 1), 32'h01020304, 32'h0, 0);
    finish_txn("R6"); clear_all();
    // R6: second data byte refused, read phase never runs
    start_txn(mk_ctl(1, 1, 10'h044, 0, 6, 4, 1), 32'h01020304, 32'h0506, 2);
    finish_txn("R6"); clear_all();
    // R6: 10-bit read, second address byte refused
    start_txn(mk_ctl(0, 1, 10'h1C0, 1, 1, 2, 0), 32'h0, 32'h0, 1);
    finish_txn("R6"); clear_all();

    // R8: writes during a transfer are ignored
    c = mk_ctl(1, 0, 10'h066, 0, 8, 1, 0);
    start_txn(c, 32'h13121110, 32'h17161514, -1);
    while (busy !== 1'b1) @(negedge clk);
    do_write(0, mk_ctl(0, 1, 10'h001, 0, 1, 2, 0));
    @(negedge clk);
    chk("R8", ctl_q, c, "ctl write during busy");
    do_write(1, 32'hFFFFFFFF);
    do_write(2, 32'hFFFFFFFF);
    finish_txn("R8"); clear_all();

    // R10: enable with no phase
    got_q.delete();
    exp_q.delete(); exp_rx = 0; exp_err = 1;
    do_write(0, 32'h00080000);
    chk("R10", {62'd0, cause_q, stat_err}, 64'h3, "empty request flags");
    finish_txn("R10"); clear_all();

    // R7: mask gating and clear
    do_write(3, 32'd1);
    start_txn(mk_ctl(1, 0, 10'h010, 0, 2, 1, 0), 32'hABCD, 32'h0, -1);
    finish_txn("R7");
    chk("R7", {63'd0, irq}, 64'd1, "irq with mask set");
    clear_all();
    chk("R7", {63'd0, irq}, 64'd0, "irq after clear");
    do_write(3, 32'd0);

    // R9: stray response with nothing outstanding
    @(negedge clk); rsp_valid = 1; rsp_nack = 1;
    @(negedge clk); rsp_valid = 0; rsp_nack = 0;
    repeat (2) @(negedge clk);
    chk("R9", {61'd0, busy, cmd_valid, cause_q}, 0, "stray response ignored");
    start_txn(mk_ctl(0, 1, 10'h05A, 0, 1, 2, 0), 32'h0, 32'h0, -1);
    finish_txn("R9"); clear_all();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule